// File: doc/BRIEF.md
# Vectored Trap and Interrupt Unit

This block sits beside a small 32-bit processor core and decides, cycle by cycle, whether control must leave the running program. It gathers four trap conditions that the core detects internally and twelve level-sensitive interrupt request lines from external devices. If any cause is pending, it picks one 4-bit cause code and asks the core to redirect its fetch to a fixed low-memory entry point. That entry point is the code shifted left by four bits, so the entries lie at 0x00, 0x10 and so on up to 0xF0.

Hardware saves very little. The interrupted program counter goes into a trap-PC register. For a bus fault, the faulting address goes into a trap-address register. Everything else is left to the handler. The handler gets one scratch register that it can write and read through the special-register port. It uses this register to free one general register before it saves the others. A return-from-trap command redirects fetch back to the saved program counter and turns interrupts on again. A global interrupt-enable bit gates the external lines. Taking any trap clears that bit. Internal traps cannot be masked.

Top module: `trap_unit`

## Requirements
- R1: While `take_o` is high, `target_o` equals `code_o` shifted left by 4 with all other bits zero, and `redirect_o` is high. Outputs respond in the same cycle as the cause.
- R2: Cause codes are mapped as follows. Code 0 is the bus trap, raised by `ro_write_i` or `unmapped_i`. Code 1 is the undefined-opcode trap `bad_op_i`. Codes 2 and 3 are `aux_trap_i[0]` and `aux_trap_i[1]`. Code 4+k is `irq_i[k]`. When several causes are pending, the lowest code wins.
- R3: Internal causes (codes 0 to 3) are taken in any cycle, whatever the state of the enable bit and `boundary_i`.
- R4: External requests are taken only in a cycle where the enable bit is 1 and `boundary_i` is 1. Otherwise they are ignored.
- R5: After a cycle with `take_o` high, the trap-PC register holds the `pc_i` value from that cycle. It is read with select 0.
- R6: The trap-address register captures `fault_addr_i` only when code 0 is taken. Other takes leave it unchanged. It is read with select 1.
- R7: A take clears the enable bit. A return-from-trap (`rtt_i`) without a take sets the bit. The bit is read and written as bit 0 under select 3. If `rtt_i` and a write to select 3 occur in the same cycle, the return-from-trap wins.
- R8: When `rtt_i` is high and no cause is taken, `redirect_o` is high, `take_o` is low, and `target_o` equals the trap-PC register. A take in the same cycle overrides `rtt_i`.
- R9: With `sr_we_i` high, `sr_wdata_i` is written to the selected register: 0 is trap-PC, 1 is trap-address, 2 is scratch, 3 is enable. The new value is readable on `sr_rdata_o` in the next cycle. A write in a cycle with `take_o` high is dropped. `sr_rdata_o` is combinational on `sr_sel_i`.
- R10: After reset, all special registers are 0, the enable bit is 0, and `take_o` and `redirect_o` stay low while no cause is present. While no take is happening, `target_o` shows the trap-PC register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Core is at an instruction boundary |
| ro_write_i | input | 1 | Write to a read-only region |
| unmapped_i | input | 1 | Access to an unimplemented address |
| bad_op_i | input | 1 | Decoded opcode is undefined |
| aux_trap_i | input | 2 | Remaining internal causes (codes 2 and 3) |
| irq_i | input | 12 | External level requests (codes 4 to 15) |
| pc_i | input | 32 | Program counter of the current instruction |
| fault_addr_i | input | 32 | Address of the current memory access |
| rtt_i | input | 1 | Return-from-trap command |
| sr_we_i | input | 1 | Special-register write strobe |
| sr_sel_i | input | 2 | Special-register select |
| sr_wdata_i | input | 32 | Special-register write data |
| sr_rdata_o | output | 32 | Special-register read data |
| take_o | output | 1 | A cause is taken this cycle |
| code_o | output | 4 | Chosen cause code |
| redirect_o | output | 1 | Fetch must jump to `target_o` |
| target_o | output | 32 | Vector address or restored PC |
| irq_en_o | output | 1 | Global interrupt enable |

## Verification
The bench goes after several collisions.
- Several causes raised together. A design with an inverted priority would pick the highest code.
- A request line held high while the enable bit is off or `boundary_i` is low. A design that ignores the mask would vector early.
- A trap arriving together with `rtt_i` or with a special-register write. A wrong design would return instead of trapping, or would commit the write.
- Non-bus traps. A design that loads the trap-address register on every take would overwrite the address captured by an earlier bus fault.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned N_INT     = 4;
  localparam int unsigned VEC_SHIFT = 4;

  typedef enum logic [1:0] {
    SR_TPC = 2'd0,
    SR_TMA = 2'd1,
    SR_TSV = 2'd2,
    SR_CTL = 2'd3
  } sr_sel_e;
endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int unsigned N      = 16,
  localparam int unsigned CODE_W = $clog2(N)
) (
  input  logic [N-1:0]      req_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = CODE_W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/trap_sregs.sv
module trap_sregs
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            bus_fault_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic            rtt_i,
  input  logic            we_i,
  input  sr_sel_e         sel_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] tpc_o,
  output logic            ie_o,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] tpc_q, tma_q, tsv_q;
  logic            ie_q;
  logic            wr;

  assign wr = we_i & ~take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpc_q <= '0;
      tma_q <= '0;
      tsv_q <= '0;
      ie_q  <= 1'b0;
    end else if (take_i) begin
      tpc_q <= pc_i;
      if (bus_fault_i) tma_q <= fault_addr_i;
      ie_q  <= 1'b0;
    end else begin
      if (wr) begin
        unique case (sel_i)
          SR_TPC: tpc_q <= wdata_i;
          SR_TMA: tma_q <= wdata_i;
          SR_TSV: tsv_q <= wdata_i;
          SR_CTL: ie_q  <= wdata_i[0];
          default: ;
        endcase
      end
      if (rtt_i) ie_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (sel_i)
      SR_TPC:  rdata_o = tpc_q;
      SR_TMA:  rdata_o = tma_q;
      SR_TSV:  rdata_o = tsv_q;
      SR_CTL:  rdata_o = {{(XLEN-1){1'b0}}, ie_q};
      default: rdata_o = '0;
    endcase
  end

  assign tpc_o = tpc_q;
  assign ie_o  = ie_q;
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned N_EXT = 12,
  localparam int unsigned N_CAUSE = N_INT + N_EXT,
  localparam int unsigned CODE_W  = $clog2(N_CAUSE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              ro_write_i,
  input  logic              unmapped_i,
  input  logic              bad_op_i,
  input  logic [1:0]        aux_trap_i,
  input  logic [N_EXT-1:0]  irq_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic              rtt_i,
  input  logic              sr_we_i,
  input  logic [1:0]        sr_sel_i,
  input  logic [XLEN-1:0]   sr_wdata_i,
  output logic [XLEN-1:0]   sr_rdata_o,
  output logic              take_o,
  output logic [CODE_W-1:0] code_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              irq_en_o
);
  logic [N_INT-1:0]   int_req;
  logic [N_EXT-1:0]   ext_req;
  logic [N_CAUSE-1:0] all_req;
  logic [XLEN-1:0]    tpc_q;
  logic [XLEN-1:0]    vec;
  logic               ie;
  logic               take;
  logic [CODE_W-1:0]  code;

  assign int_req = {aux_trap_i, bad_op_i, ro_write_i | unmapped_i};
  // external lines only at a boundary with interrupts on
  assign ext_req = irq_i & {N_EXT{ie & boundary_i}};
  assign all_req = {ext_req, int_req};

  trap_prio #(.N(N_CAUSE)) u_prio (
    .req_i   (all_req),
    .valid_o (take),
    .code_o  (code)
  );

  trap_sregs #(.XLEN(XLEN)) u_sregs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .bus_fault_i  (code == '0),
    .pc_i         (pc_i),
    .fault_addr_i (fault_addr_i),
    .rtt_i        (rtt_i),
    .we_i         (sr_we_i),
    .sel_i        (sr_sel_e'(sr_sel_i)),
    .wdata_i      (sr_wdata_i),
    .tpc_o        (tpc_q),
    .ie_o         (ie),
    .rdata_o      (sr_rdata_o)
  );

  assign vec        = XLEN'({code, {VEC_SHIFT{1'b0}}});
  assign take_o     = take;
  assign code_o     = code;
  assign redirect_o = take | rtt_i;
  assign target_o   = take ? vec : tpc_q;
  assign irq_en_o   = ie;
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              take_o,
  input logic [CODE_W-1:0] code_o,
  input logic              redirect_o,
  input logic [XLEN-1:0]   target_o,
  input logic              irq_en_o,
  input logic              boundary_i,
  input logic              rtt_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   tpc_q,
  input logic [3:0]        int_req
);
  localparam int unsigned SH = trap_pkg::VEC_SHIFT;

  a_r1_vector_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> redirect_o && target_o[SH-1:0] == '0
               && target_o[SH +: CODE_W] == code_o
               && target_o[XLEN-1:SH+CODE_W] == '0);

  a_r3_internal_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|int_req) |-> take_o && code_o < CODE_W'(4));

  a_r4_ext_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && code_o >= CODE_W'(4)) |-> irq_en_o && boundary_i);

  a_r5_pc_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> tpc_q == $past(pc_i));

  a_r7_ie_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !irq_en_o);

  a_r8_return_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtt_i && !take_o) |-> redirect_o && target_o == tpc_q);
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .take_o     (take_o),
  .code_o     (code_o),
  .redirect_o (redirect_o),
  .target_o   (target_o),
  .irq_en_o   (irq_en_o),
  .boundary_i (boundary_i),
  .rtt_i      (rtt_i),
  .pc_i       (pc_i),
  .tpc_q      (tpc_q),
  .int_req    (int_req)
);

// File: tb/trap_unit_tb_top.sv
module trap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd = 0, ro_w = 0, unm = 0, bad = 0, rtt = 0, we = 0;
  logic [1:0]  aux = 0, sel = 0;
  logic [11:0] irq = 0;
  logic [31:0] pc = 0, fa = 0, wd = 0;
  logic [31:0] rdata, target;
  logic        take, redir, ie;
  logic [3:0]  code;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [31:0] m_tpc = 0, m_tma = 0, m_tsv = 0;
  logic        m_ie = 0;

  always #10 clk = ~clk;

  trap_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(bnd), .ro_write_i(ro_w),
    .unmapped_i(unm), .bad_op_i(bad), .aux_trap_i(aux), .irq_i(irq),
    .pc_i(pc), .fault_addr_i(fa), .rtt_i(rtt), .sr_we_i(we),
    .sr_sel_i(sel), .sr_wdata_i(wd), .sr_rdata_o(rdata), .take_o(take),
    .code_o(code), .redirect_o(redir), .target_o(target), .irq_en_o(ie)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs against the model, then advance the model on the edge
  task automatic cycle();
    logic [15:0] pend;
    logic        e_take;
    logic [3:0]  e_code;
    logic [31:0] e_rd;
    #1;
    pend = {(m_ie && bnd) ? irq : 12'h000, aux, bad, ro_w | unm};
    e_take = pend != 0;
    e_code = 0;
    for (int i = 15; i >= 0; i--) if (pend[i]) e_code = 4'(i);
    case (sel)
      2'd0: e_rd = m_tpc;
      2'd1: e_rd = m_tma;
      2'd2: e_rd = m_tsv;
      default: e_rd = {31'b0, m_ie};
    endcase
    chk(32'(take), 32'(e_take), (pend[3:0] != 0) ? "R3 take" : "R4 take");
    if (e_take) chk(32'(code), 32'(e_code), "R2 code");
    chk(32'(redir), 32'(e_take | rtt), e_take ? "R1 redirect" : "R8 redirect");
    chk(target, e_take ? {24'b0, e_code, 4'b0} : m_tpc, e_take ? "R1 target" : "R8 target");
    chk(32'(ie), 32'(m_ie), "R7 enable");
    chk(rdata, e_rd, sel == 0 ? "R5 read tpc" : sel == 1 ? "R6 read tma" : "R9 read");
    @(posedge clk);
    if (e_take) begin
      m_tpc = pc;
      if (e_code == 0) m_tma = fa;
      m_ie = 0;
    end else begin
      if (we) case (sel)
        2'd0: m_tpc = wd;
        2'd1: m_tma = wd;
        2'd2: m_tsv = wd;
        default: m_ie = wd[0];
      endcase
      if (rtt) m_ie = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    bnd = 0; ro_w = 0; unm = 0; bad = 0; aux = 0; irq = 0; rtt = 0; we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #25;
    // R10 reset state
    chk(32'(take), 0, "R10 take in reset");
    chk(32'(redir), 0, "R10 redirect in reset");
    chk(32'(ie), 0, "R10 enable in reset");
    chk(rdata, 0, "R10 tpc in reset");
    @(negedge clk); rst_n = 1;
    cycle();
    // R9 scratch write/read
    sel = 2; we = 1; wd = 32'hCAFE_0001; cycle();
    we = 0; cycle();
    // R4 irq while disabled is ignored
    irq = 12'h010; bnd = 1; cycle();
    // R7 enable via control write
    irq = 0; sel = 3; we = 1; wd = 1; cycle();
    we = 0; cycle();
    // R4 irq off-boundary ignored, then taken at boundary
    irq = 12'h030; bnd = 0; pc = 32'h400; cycle();
    bnd = 1; cycle();
    idle(); sel = 0; cycle();
    // R8 return, then R2 several internal together, R6 bus fault capture
    rtt = 1; cycle();
    rtt = 0; bad = 1; aux = 2'b11; unm = 1; fa = 32'hDEAD_BEE0; pc = 32'h88; cycle();
    idle(); sel = 1; cycle();
    // R6 non-bus trap keeps tma; R9 write dropped on take
    bad = 1; fa = 32'h1234; we = 1; sel = 2; wd = 32'h5555; cycle();
    idle(); cycle();
    sel = 1; cycle();
    // R8 trap overrides rtt; R7 rtt beats control write
    aux = 2'b01; rtt = 1; cycle();
    idle(); rtt = 1; we = 1; sel = 3; wd = 0; cycle();
    idle(); cycle();
    // random run
    for (int n = 0; n < 3000; n++) begin
      bnd  = ($urandom % 3) != 0;
      ro_w = ($urandom % 40) == 0;
      unm  = ($urandom % 40) == 0;
      bad  = ($urandom % 30) == 0;
      aux  = (($urandom % 25) == 0) ? 2'($urandom) : 2'b00;
      irq  = (($urandom % 4) == 0) ? 12'($urandom) : 12'h000;
      pc   = $urandom; fa = $urandom; wd = $urandom;
      rtt  = ($urandom % 8) == 0;
      we   = ($urandom % 5) == 0;
      sel  = 2'($urandom);
      cycle();
    end
    finish_run();
  end
endmodule